// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It takes a 4-bit condition selector and the four arithmetic status flags left by the last flag-setting instruction: negative, zero, carry and overflow. From these it drives one take-branch output. Besides simple flag tests it decodes the unsigned and signed relational conditions that follow a compare. There is also an always-taken code and a never-taken code.

The unit is purely combinational and keeps no state. The branch stage of a pipeline feeds it the selector from the instruction and the flags from the status register. The stage then uses the result in the same cycle to choose between the fall-through address and the branch target. The data is one set of values per cycle with no transfer semantics, so the pins are plain and there is no valid/ready handshake. Back-pressure does not apply. The caller holds the inputs for as long as it needs the answer.

Top module: `brcond_eval`

## Requirements
- R1: Code 4'b0000 (equal) asserts `take` exactly when Z = 1; code 4'b0001 (not equal) asserts it exactly when Z = 0.
- R2: Code 4'b0010 (carry set, unsigned higher-or-same) asserts `take` when C = 1; code 4'b0011 (carry clear, unsigned lower) asserts it when C = 0.
- R3: Code 4'b0100 (negative) asserts `take` when N = 1; code 4'b0101 (positive or zero) asserts it when N = 0.
- R4: Code 4'b0110 (overflow) asserts `take` when V = 1; code 4'b0111 (no overflow) asserts it when V = 0.
- R5: Code 4'b1000 (unsigned higher) asserts `take` when C = 1 and Z = 0; code 4'b1001 (unsigned lower-or-same) asserts it when C = 0 or Z = 1.
- R6: Code 4'b1010 (signed greater-or-equal) asserts `take` when N equals V; code 4'b1011 (signed less-than) asserts it when N differs from V.
- R7: Code 4'b1100 (signed greater-than) asserts `take` when N equals V and Z = 0; code 4'b1101 (signed less-or-equal) asserts it when Z = 1 or N differs from V.
- R8: Code 4'b1110 asserts `take` for every flag value; code 4'b1111 never asserts it.
- R9: For every flag combination, the two codes that differ only in bit 0 give opposite values of `take`.
- R10: `take` depends only on the present inputs. It settles within the cycle in which they change and does not depend on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel | input | 4 | Condition selector from the branch instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| take | output | 1 | High when the selected condition holds |

## Verification
Every one of the sixteen selectors is applied with all sixteen N/Z/C/V combinations. Each condition is therefore seen both where one flag alone decides it and where flags that should not matter are toggled. A wrong flag choice and a stray dependence both show up this way. Mixed patterns decide the compound codes. Z = 1 together with N = V separates greater-than from greater-or-equal, and C = 1 together with Z = 1 separates higher from higher-or-same. Directed passes then compare each even/odd pair on the same flags to confirm they are exact complements. Further passes change the inputs in a different order to show the output carries nothing over from earlier inputs.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  localparam int unsigned SEL_W   = 4;
  localparam int unsigned PAIRS   = 1 << (SEL_W - 1);
  localparam int unsigned PAIR_W  = SEL_W - 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_EQ = 4'b0000,
    SEL_NE = 4'b0001,
    SEL_CS = 4'b0010,
    SEL_CC = 4'b0011,
    SEL_MI = 4'b0100,
    SEL_PL = 4'b0101,
    SEL_VS = 4'b0110,
    SEL_VC = 4'b0111,
    SEL_HI = 4'b1000,
    SEL_LS = 4'b1001,
    SEL_GE = 4'b1010,
    SEL_LT = 4'b1011,
    SEL_GT = 4'b1100,
    SEL_LE = 4'b1101,
    SEL_AL = 4'b1110,
    SEL_NV = 4'b1111
  } cond_sel_e;

  // Pair index = selector bits [3:1]; even member is the base predicate.
  typedef enum logic [PAIR_W-1:0] {
    PR_ZERO  = 3'd0,
    PR_CARRY = 3'd1,
    PR_NEG   = 3'd2,
    PR_OVF   = 3'd3,
    PR_UHI   = 3'd4,
    PR_SGE   = 3'd5,
    PR_SGT   = 3'd6,
    PR_ALL   = 3'd7
  } pair_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/brcond_base.sv
// Produces the base (even-code) predicate of every condition pair.
module brcond_base
  import brcond_pkg::*;
(
  input  flags_t             flags,
  output logic [PAIRS-1:0]   base
);

  logic sign_match;

  always_comb begin
    sign_match = ~(flags.n ^ flags.v);
    base = '0;
    base[PR_ZERO]  = flags.z;
    base[PR_CARRY] = flags.c;
    base[PR_NEG]   = flags.n;
    base[PR_OVF]   = flags.v;
    base[PR_UHI]   = flags.c & ~flags.z;
    base[PR_SGE]   = sign_match;
    base[PR_SGT]   = sign_match & ~flags.z;
    base[PR_ALL]   = 1'b1;
  end

endmodule

// File: rtl/brcond_pick.sv
// Selects one pair predicate and applies the odd-code inversion.
module brcond_pick
  import brcond_pkg::*;
(
  input  logic [PAIRS-1:0]  base,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit
);

  logic [PAIR_W-1:0] pair_idx;
  logic              invert;
  logic [PAIRS-1:0]  onehot;

  assign pair_idx = sel[SEL_W-1:1];
  assign invert   = sel[0];

  for (genvar g = 0; g < PAIRS; g++) begin : g_dec
    assign onehot[g] = (pair_idx == PAIR_W'(g));
  end

  logic chosen;
  assign chosen = |(onehot & base);
  assign hit    = chosen ^ invert;

endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
  import brcond_pkg::*;
(
  input  logic [3:0] cond_sel,
  input  logic       flag_n,
  input  logic       flag_z,
  input  logic       flag_c,
  input  logic       flag_v,
  output logic       take
);

  flags_t           flags;
  logic [PAIRS-1:0] base;

  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  brcond_base u_base (
    .flags (flags),
    .base  (base)
  );

  brcond_pick u_pick (
    .base (base),
    .sel  (cond_sel),
    .hit  (take)
  );

endmodule

// File: rtl/brcond_eval_chk.sv
module brcond_eval_chk (
  input logic [3:0] cond_sel,
  input logic       flag_n,
  input logic       flag_z,
  input logic       flag_c,
  input logic       flag_v,
  input logic       take
);

  always_comb begin
    if (cond_sel == 4'd0) p_eq_zero_r1: assert (take == flag_z);
    if (cond_sel == 4'd1) p_ne_zero_r1: assert (take != flag_z);
    if (cond_sel[3:1] == 3'd1) p_carry_r2: assert (take == (flag_c ^ cond_sel[0]));
    if (cond_sel[3:1] == 3'd2) p_neg_r3: assert (take == (flag_n ^ cond_sel[0]));
    if (cond_sel[3:1] == 3'd3) p_ovf_r4: assert (take == (flag_v ^ cond_sel[0]));
    if (cond_sel == 4'd8 && flag_z) p_hi_zero_r5: assert (!take);
    if (cond_sel == 4'd9 && !flag_c) p_ls_nocarry_r5: assert (take);
    if (cond_sel == 4'd10 && (flag_n != flag_v)) p_ge_mismatch_r6: assert (!take);
    if (cond_sel == 4'd11 && (flag_n == flag_v)) p_lt_match_r6: assert (!take);
    if (cond_sel == 4'd12 && flag_z) p_gt_zero_r7: assert (!take);
    if (cond_sel == 4'd13 && flag_z) p_le_zero_r7: assert (take);
    if (cond_sel == 4'd14) p_always_r8: assert (take);
    if (cond_sel == 4'd15) p_never_r8: assert (!take);
  end

endmodule

bind brcond_eval brcond_eval_chk u_chk (
  .cond_sel (cond_sel),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_c   (flag_c),
  .flag_v   (flag_v),
  .take     (take)
);

// File: tb/tb_brcond_eval.sv
module tb_brcond_eval;

  logic       clk = 1'b0;
  logic [3:0] cond_sel = 4'd0;
  logic       flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic       take;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  brcond_eval dut (
    .cond_sel (cond_sel),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .flag_v   (flag_v),
    .take     (take)
  );

  // Truth mask per selector: bit f set means taken for flags f = {N,Z,C,V}.
  localparam logic [15:0] MASKS [16] = '{
    16'hF0F0, 16'h0F0F,   // EQ NE
    16'hCCCC, 16'h3333,   // CS CC
    16'hFF00, 16'h00FF,   // MI PL
    16'hAAAA, 16'h5555,   // VS VC
    16'h0C0C, 16'hF3F3,   // HI LS
    16'hAA55, 16'h55AA,   // GE LT
    16'h0A05, 16'hF5FA,   // GT LE
    16'hFFFF, 16'h0000    // AL NV
  };

  function automatic string req_of(input int code);
    case (code >> 1)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [3:0] sel, input logic [3:0] f);
    @(posedge clk);
    {cond_sel, flag_n, flag_z, flag_c, flag_v} = {sel, f};
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic got, input logic exp,
                       input logic [3:0] sel, input logic [3:0] f);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s sel=%b nzcv=%b take=%b expected=%b", req, sel, f, got, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired take=%b expected=finish", take);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // Initial state: selector EQ with all flags clear -> not taken (R1).
    #1;
    check("R1", take, 1'b0, 4'd0, 4'd0);

    // Table walk: every selector against every flag combination.
    for (int idx = 0; idx < 256; idx++) begin
      logic [3:0] s = 4'(idx >> 4);
      logic [3:0] f = 4'(idx);
      apply(s, f);
      check(req_of(idx >> 4), take, MASKS[s][f], s, f);
    end

    // R9: even/odd pairs are complementary on identical flags.
    for (int p = 0; p < 8; p++) begin
      for (int f = 0; f < 16; f++) begin
        logic even_out;
        apply(4'(2 * p), 4'(f));
        even_out = take;
        apply(4'(2 * p + 1), 4'(f));
        check("R9", take, ~even_out, 4'(2 * p + 1), 4'(f));
      end
    end

    // R5/R7 corners: carry with zero, sign match with zero.
    apply(4'd8, 4'b0110);  check("R5", take, 1'b0, 4'd8, 4'b0110);
    apply(4'd2, 4'b0110);  check("R2", take, 1'b1, 4'd2, 4'b0110);
    apply(4'd12, 4'b0100); check("R7", take, 1'b0, 4'd12, 4'b0100);
    apply(4'd10, 4'b0100); check("R6", take, 1'b1, 4'd10, 4'b0100);
    apply(4'd12, 4'b1001); check("R7", take, 1'b1, 4'd12, 4'b1001);

    // R10: descending order of flags, no memory of prior inputs.
    for (int f = 15; f >= 0; f--) begin
      apply(4'd13, 4'(f));
      check("R10", take, MASKS[13][f], 4'd13, 4'(f));
    end
    // R10: change flags mid-cycle; output follows within the same cycle.
    @(posedge clk);
    {cond_sel, flag_n, flag_z, flag_c, flag_v} = {4'd0, 4'b0100};
    #1;
    check("R10", take, 1'b1, 4'd0, 4'b0100);
    flag_z = 1'b0;
    #1;
    check("R10", take, 1'b0, 4'd0, 4'b0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule